// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a processor virtual address into a physical address using a single-level page table held inside the block. The low bits of the virtual address are the displacement within a page, and the high bits are the virtual page number. The page number selects one table entry directly. That entry holds a physical page number, a displacement limit and a valid bit. The physical address is built from the physical page number and the displacement. A static mode pin selects how: the two fields are either placed side by side, or the physical page number is shifted by a parameter amount and added to the displacement. The physical page field may be narrower, wider or equal in width to the virtual page field.

A configuration write port loads one entry per cycle. Requests and responses are streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the single response slot is empty, or when that slot is being drained in the same cycle. The response is raised one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response holds all of its fields unchanged and no new request is taken.

Each response carries two fault flags. A page fault means the entry was invalid; the address is then meaningless. A bounds fault means the displacement was larger than the entry's limit; this check is present only when `BOUND_EN` is 1. If address arithmetic carries into the page field, the translator simply uses the following page's entry and raises no fault for the carry.

Top module: `page_xlate`

## Requirements
- R1: The displacement is `req_vaddr[DISP_W-1:0]`. The virtual page number is `req_vaddr[VA_W-1:DISP_W]`, where `VA_W = VPN_W + DISP_W`.
- R2: The virtual page number indexes the table directly. A write with `cfg_we`=1 stores `cfg_ppn`, `cfg_limit` and `cfg_valid` at index `cfg_index`, and later lookups of that index return the stored physical page number.
- R3: When `mode`=0 (concatenation), `rsp_paddr` = {ppn, displacement}, zero-extended to `PA_W` bits.
- R4: When `mode`=1 (addition), `rsp_paddr` = (ppn << `ADD_SHIFT`) + displacement, computed without loss in `PA_W` bits.
- R5: `PPN_W` is independent of `VPN_W`. The bench uses `PPN_W` > `VPN_W`, and the full ppn value appears in `rsp_paddr`.
- R6: A virtual address whose page field was incremented by a carry translates through the next page's entry with no fault.
- R7: A lookup that hits an entry with its valid bit at 0 returns `rsp_page_fault`=1 and `rsp_bound_fault`=0. The two faults never appear together.
- R8: With `BOUND_EN`=1, `rsp_bound_fault`=1 exactly when a valid entry is hit and displacement > limit. A displacement equal to the limit does not fault.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request gives `rsp_valid`=1 on the next cycle. A consumed response with no new acceptance drops `rsp_valid`.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_paddr`, `rsp_page_fault` and `rsp_bound_fault` stay stable.
- R11: A table write and a lookup of the same index on the same edge return the entry as it was before the write.
- R12: Synchronous active-high `rst` clears every valid bit and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0: concatenate, 1: shift and add (static) |
| cfg_we | input | 1 | Table write enable |
| cfg_index | input | VPN_W | Entry to write |
| cfg_ppn | input | PPN_W | Physical page number to store |
| cfg_limit | input | DISP_W | Highest legal displacement for the entry |
| cfg_valid | input | 1 | Valid bit to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address (meaningless on page fault) |
| rsp_page_fault | output | 1 | Entry was invalid |
| rsp_bound_fault | output | 1 | Displacement exceeded the entry limit |

## Verification
The bench builds the block with `VPN_W`=3, `DISP_W`=4, `PPN_W`=5, `ADD_SHIFT`=3 and `BOUND_EN`=1. With these values the 8-entry table and all 128 virtual addresses can be swept completely in both modes. Because the shift is smaller than the displacement width, the addition mode really overlaps the fields and produces carries. The wider physical page field checks that its top bit is carried through. Limits spread across the whole displacement range cover the equal-to-limit edge and the just-over-limit edge on every page.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

  typedef enum logic {
    FORM_CAT = 1'b0,
    FORM_ADD = 1'b1
  } form_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // physical address width wide enough for either forming mode without loss
  function automatic int pa_width(input int ppn_w, input int disp_w, input int shift);
    return max2(ppn_w + disp_w, ppn_w + shift) + 1;
  endfunction

endpackage

// File: rtl/pxl_table.sv
module pxl_table #(
  parameter int IDX_W  = 3,
  parameter int PPN_W  = 5,
  parameter int LIM_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [LIM_W-1:0] wr_lim,
  input  logic             wr_vld,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn,
  output logic [LIM_W-1:0] rd_lim,
  output logic             rd_vld
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PPN_W-1:0] ppn_mem [DEPTH];
  logic [LIM_W-1:0] lim_mem [DEPTH];
  logic [DEPTH-1:0] vld_bits;

  // valid bits carry reset; read happens on the same edge as write (old value)
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_bits <= '0;
      rd_vld   <= 1'b0;
    end else begin
      if (rd_en) rd_vld <= vld_bits[rd_idx];
      if (wr_en) vld_bits[wr_idx] <= wr_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_ppn <= ppn_mem[rd_idx];
      rd_lim <= lim_mem[rd_idx];
    end
    if (wr_en) begin
      ppn_mem[wr_idx] <= wr_ppn;
      lim_mem[wr_idx] <= wr_lim;
    end
  end
endmodule

// File: rtl/pxl_former.sv
module pxl_former
  import page_xlate_pkg::*;
#(
  parameter int PPN_W     = 5,
  parameter int DISP_W    = 4,
  parameter int ADD_SHIFT = 3,
  parameter bit BOUND_EN  = 1'b1,
  localparam int PA_W     = pa_width(PPN_W, DISP_W, ADD_SHIFT)
) (
  input  form_e             form,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [DISP_W-1:0] disp,
  input  logic [DISP_W-1:0] lim,
  input  logic              hit,
  output logic [PA_W-1:0]   paddr,
  output logic              page_flt,
  output logic              bnd_flt
);
  localparam int PPN_PAD  = PA_W - PPN_W;
  localparam int DISP_PAD = PA_W - DISP_W;
  localparam int CAT_PAD  = PA_W - PPN_W - DISP_W;

  logic [PA_W-1:0] cat_addr;
  logic [PA_W-1:0] add_addr;

  assign cat_addr = {{CAT_PAD{1'b0}}, ppn, disp};
  assign add_addr = ({{PPN_PAD{1'b0}}, ppn} << ADD_SHIFT) + {{DISP_PAD{1'b0}}, disp};

  always_comb begin
    paddr = (form == FORM_ADD) ? add_addr : cat_addr;
  end

  assign page_flt = !hit;

  generate
    if (BOUND_EN) begin : g_bound
      assign bnd_flt = hit && (disp > lim);
    end else begin : g_nobound
      assign bnd_flt = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pxl_slot.sv
module pxl_slot (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic take,
  output logic out_valid,
  input  logic out_ready
);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)                    out_valid <= 1'b0;
    else if (take)              out_valid <= 1'b1;
    else if (out_ready)         out_valid <= 1'b0;
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int VPN_W     = 3,
  parameter int DISP_W    = 4,
  parameter int PPN_W     = 5,
  parameter int ADD_SHIFT = 3,
  parameter bit BOUND_EN  = 1'b1,
  localparam int VA_W     = VPN_W + DISP_W,
  localparam int PA_W     = pa_width(PPN_W, DISP_W, ADD_SHIFT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              cfg_we,
  input  logic [VPN_W-1:0]  cfg_index,
  input  logic [PPN_W-1:0]  cfg_ppn,
  input  logic [DISP_W-1:0] cfg_limit,
  input  logic              cfg_valid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_page_fault,
  output logic              rsp_bound_fault
);
  logic              take;
  logic [VPN_W-1:0]  req_vpn;
  logic [DISP_W-1:0] req_disp;
  logic [DISP_W-1:0] disp_q;
  logic [PPN_W-1:0]  ent_ppn;
  logic [DISP_W-1:0] ent_lim;
  logic              ent_vld;

  assign req_vpn  = req_vaddr[VA_W-1:DISP_W];
  assign req_disp = req_vaddr[DISP_W-1:0];

  pxl_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .take      (take),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready)
  );

  pxl_table #(.IDX_W(VPN_W), .PPN_W(PPN_W), .LIM_W(DISP_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_idx (cfg_index),
    .wr_ppn (cfg_ppn),
    .wr_lim (cfg_limit),
    .wr_vld (cfg_valid),
    .rd_en  (take),
    .rd_idx (req_vpn),
    .rd_ppn (ent_ppn),
    .rd_lim (ent_lim),
    .rd_vld (ent_vld)
  );

  always_ff @(posedge clk) begin
    if (take) disp_q <= req_disp;
  end

  pxl_former #(
    .PPN_W(PPN_W), .DISP_W(DISP_W), .ADD_SHIFT(ADD_SHIFT), .BOUND_EN(BOUND_EN)
  ) u_former (
    .form     (form_e'(mode)),
    .ppn      (ent_ppn),
    .disp     (disp_q),
    .lim      (ent_lim),
    .hit      (ent_vld),
    .paddr    (rsp_paddr),
    .page_flt (rsp_page_fault),
    .bnd_flt  (rsp_bound_fault)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int PA_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_page_fault,
  input logic            rsp_bound_fault
);
  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_accept_gives_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_drain_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  assert_stall_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_page_fault) && $stable(rsp_bound_fault)));

  assert_faults_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_page_fault && rsp_bound_fault));

  assert_reset_empty_R12: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);
endmodule

bind page_xlate page_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_paddr       (rsp_paddr),
  .rsp_page_fault  (rsp_page_fault),
  .rsp_bound_fault (rsp_bound_fault)
);

// File: tb/page_xlate_test.sv
`timescale 1ns/1ps
module page_xlate_test;
  localparam int VPN_W = 3, DISP_W = 4, PPN_W = 5, SHIFT = 3;
  localparam int VA_W = VPN_W + DISP_W;
  localparam int PA_W = 10;
  localparam int NENT = 1 << VPN_W;

  logic clk = 0, rst = 1, mode = 0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [VPN_W-1:0] cfg_index = '0;
  logic [PPN_W-1:0] cfg_ppn = '0;
  logic [DISP_W-1:0] cfg_limit = '0;
  logic req_valid = 0, rsp_ready = 1;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_page_fault, rsp_bound_fault;
  logic [PA_W-1:0] rsp_paddr;

  int m_ppn [NENT];
  int m_lim [NENT];
  bit m_val [NENT];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  page_xlate #(.VPN_W(VPN_W), .DISP_W(DISP_W), .PPN_W(PPN_W),
               .ADD_SHIFT(SHIFT), .BOUND_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .mode(mode), .cfg_we(cfg_we), .cfg_index(cfg_index),
    .cfg_ppn(cfg_ppn), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_page_fault(rsp_page_fault), .rsp_bound_fault(rsp_bound_fault));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare the present response to the model for address va in mode md
  task automatic check_rsp(input string tag, input int va, input bit md);
    int pg, ds, ea;
    pg = va >> DISP_W;
    ds = va % (1 << DISP_W);
    ea = md ? (m_ppn[pg] * (1 << SHIFT) + ds) : (m_ppn[pg] * (1 << DISP_W) + ds);
    chk({tag, " R9 rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " R7 page fault"}, int'(rsp_page_fault), m_val[pg] ? 0 : 1);
    chk({tag, " R8 bound fault"}, int'(rsp_bound_fault),
        (m_val[pg] && ds > m_lim[pg]) ? 1 : 0);
    if (m_val[pg]) chk({tag, md ? " R4 add paddr" : " R3 cat paddr"}, int'(rsp_paddr), ea);
  endtask

  task automatic write_ent(input int idx, input int ppn, input int lim, input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_index = idx[VPN_W-1:0]; cfg_ppn = ppn[PPN_W-1:0];
    cfg_limit = lim[DISP_W-1:0]; cfg_valid = v;
    @(negedge clk);
    cfg_we = 0;
    m_ppn[idx] = ppn; m_lim[idx] = lim; m_val[idx] = v;
  endtask

  task automatic lookup(input string tag, input int va, input bit md);
    @(negedge clk);
    mode = md; rsp_ready = 1; req_valid = 1; req_vaddr = va[VA_W-1:0];
    @(negedge clk);
    req_valid = 0;
    check_rsp(tag, va, md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin m_ppn[i] = 0; m_lim[i] = 0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset state
    chk("R12 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R9 req_ready after reset", int'(req_ready), 1);
    lookup("R12 empty table", 7, 0);

    // R2 R5: load entries, ppn uses the full 5-bit range, two entries invalid
    for (int i = 0; i < NENT; i++)
      write_ent(i, (i * 7 + 3 + (i == 7 ? 8 : 0)) % 32, (i * 5 + 2) % 16, (i != 2 && i != 6));

    // R1 R3 R4 R7 R8: exhaustive sweep in both modes
    for (int md = 0; md < 2; md++)
      for (int va = 0; va < (1 << VA_W); va++)
        lookup("R1 sweep", va, md[0]);

    // R6: carry from displacement into page field uses the next entry silently
    lookup("R6 carry", (3 << DISP_W) + 15 + 1, 1);

    // R10: stall holds response, blocks the next request
    @(negedge clk);
    mode = 0; rsp_ready = 0; req_valid = 1; req_vaddr = 7'(5 << DISP_W | 9);
    @(negedge clk);
    req_vaddr = 7'(1 << DISP_W | 3);
    chk("R9 req_ready under stall", int'(req_ready), 0);
    check_rsp("R10 stall first", (5 << DISP_W) | 9, 0);
    repeat (3) @(negedge clk);
    chk("R9 req_ready still stalled", int'(req_ready), 0);
    check_rsp("R10 stall held", (5 << DISP_W) | 9, 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check_rsp("R9 second after drain", (1 << DISP_W) | 3, 0);
    @(negedge clk);
    chk("R9 drained", int'(rsp_valid), 0);

    // R11: same-edge write and lookup return the old entry
    @(negedge clk);
    mode = 1; cfg_we = 1; cfg_index = 3'd5; cfg_ppn = 5'd30; cfg_limit = 4'd15; cfg_valid = 1;
    req_valid = 1; req_vaddr = 7'(5 << DISP_W | 4);
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check_rsp("R11 old entry", (5 << DISP_W) | 4, 1);
    m_ppn[5] = 30; m_lim[5] = 15; m_val[5] = 1;
    lookup("R11 new entry", (5 << DISP_W) | 4, 1);
    lookup("R2 rewritten concat", (5 << DISP_W) | 15, 0);

    // R12: reset mid-run invalidates the table
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < NENT; i++) m_val[i] = 0;
    chk("R12 rsp_valid after second reset", int'(rsp_valid), 0);
    lookup("R12 invalidated", (5 << DISP_W) | 4, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule